// File: doc/BRIEF.md
# Serial Memory Bus Slave Front-End

This block sits between the four-wire serial bus pins of a memory device and its internal core. All pins are oversampled by a fast system clock. Each pin passes through a synchroniser, and edge detectors turn the serial clock, chip select and hardware reset pin into single-cycle events. While a transaction is open, a bit on the data input is taken at every rising serial clock. Bits are assembled most significant bit first. Every completed byte is handed to the core with a one-cycle strobe. A flag marks the opening byte of a transaction as the instruction.

For reads, the core answers each delivered byte by placing a reply on a parallel input. At the first falling serial clock after the byte completes, the block loads that reply and shifts it out, most significant bit first. The output changes only on falling serial clock edges. The block also keeps a power-up gate: nothing is accepted until chip select has been seen to fall.

A hardware reset pin puts the block into reset mode and re-arms that gate. If an internal cycle is running when the pin drops, the block reports the abort. A two-bit power state summarises reset, standby, active and busy.

Top module: `spi_mem_frontend`

## Requirements
- R1: Bits on `sdi_i` are taken on rising `sclk_i` edges and assembled MSB first. After the eighth bit of a transaction, `rx_byte_o` holds the byte and `rx_valid_o` pulses for one cycle with `rx_instr_o` = 1.
- R2: After the instruction byte, every further group of eight bits in the same transaction is delivered the same way with `rx_instr_o` = 0.
- R3: A rising edge of `cs_n_i` closes the transaction. A partly received byte is never delivered, and the next transaction starts again with an instruction byte.
- R4: After system reset, no bit is accepted until a falling edge of `cs_n_i` has been seen. If chip select is already low when reset ends, bits clocked in are discarded.
- R5: `sdo_o` changes only after falling `sclk_i` edges. At the first falling edge after each completed byte, `tx_byte_i` is loaded and then shifted out MSB first, one bit per falling edge. During the instruction byte, `sdo_o` is 0.
- R6: While `cs_n_i` is high, `sdo_oe_o` is 0. While it is low and `hw_rst_n_i` is high, `sdo_oe_o` is 1.
- R7: While `hw_rst_n_i` is low, `sdo_oe_o` is 0 and no byte is delivered. A partial byte is dropped. After the pin returns high, a new falling edge of `cs_n_i` is needed before bits are accepted.
- R8: `pwr_state_o` is 2'b00 while `hw_rst_n_i` is low. Otherwise it is 2'b10 while `cs_n_i` is low, 2'b11 while `cs_n_i` is high with `busy_i` = 1, and 2'b01 while `cs_n_i` is high with `busy_i` = 0.
- R9: A falling edge of `hw_rst_n_i` while `busy_i` = 1 gives a one-cycle `abort_o` pulse and sets `corrupt_o`. `corrupt_o` is cleared at the next accepted chip select falling edge. A falling edge with `busy_i` = 0 gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low system (power-up) reset |
| sclk_i | input | 1 | Serial clock pin |
| sdi_i | input | 1 | Serial data input pin |
| cs_n_i | input | 1 | Active-low chip select pin |
| hw_rst_n_i | input | 1 | Active-low hardware reset pin |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Output enable for the serial data output (0 = high impedance) |
| rx_byte_o | output | DATA_W | Last completed received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a completed byte |
| rx_instr_o | output | 1 | Strobed byte is the instruction byte |
| tx_byte_i | input | DATA_W | Reply byte from the core |
| busy_i | input | 1 | Core has an internal write/program/erase cycle running |
| abort_o | output | 1 | One-cycle pulse: a running internal cycle was aborted |
| corrupt_o | output | 1 | Sticky: aborted cycle, data may be corrupt |
| pwr_state_o | output | 2 | Power state: 00 reset, 01 standby, 10 active, 11 busy |

## Verification
The hardest situations to reach are those where chip select is already low when the gate is closed. One is a system reset released with the pin held low. The other is a hardware reset pulse in the middle of a transaction, with chip select never raised. In both cases a full byte of serial clocks must still produce no strobe. The bench builds both directly. It holds chip select low across the system reset release. It also drops the reset pin after half a byte and keeps clocking eight more bits before raising chip select. Randomly sized transactions with trailing partial bytes check delivery and the reply path, and directed busy and reset pin sequences cover the power states and the abort flag.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  typedef enum logic [1:0] {
    PWR_RESET   = 2'b00,
    PWR_STANDBY = 2'b01,
    PWR_ACTIVE  = 2'b10,
    PWR_BUSY    = 2'b11
  } pwr_e;

  // Power state from the synchronised pin levels and the core busy input.
  function automatic pwr_e pwr_classify(logic pin_ok, logic selected, logic busy);
    if (!pin_ok)        return PWR_RESET;
    else if (selected)  return PWR_ACTIVE;
    else if (busy)      return PWR_BUSY;
    else                return PWR_STANDBY;
  endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int       STAGES = 2,
  parameter logic     INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{INIT}};
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spi_fe_edge.sv
module spi_fe_edge #(
  parameter bit RISING = 1'b1,
  parameter int SETTLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic pulse_o
);
  localparam int SW = $clog2(SETTLE + 1);
  localparam logic [SW-1:0] SETTLE_V = SW'(SETTLE);

  logic          prev;
  logic [SW-1:0] settle_cnt;
  logic          ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev       <= 1'b0;
      settle_cnt <= '0;
    end else begin
      prev <= d_i;
      if (settle_cnt != SETTLE_V) settle_cnt <= settle_cnt + 1'b1;
    end
  end

  // Edges are masked until the synchroniser holds real pin values.
  assign ready = (settle_cnt == SETTLE_V);

  generate
    if (RISING) begin : g_rise
      assign pulse_o = ready & d_i & ~prev;
    end else begin : g_fall
      assign pulse_o = ready & ~d_i & prev;
    end
  endgenerate
endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
  import spi_fe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_sel,
  input  logic       cs_fall_evt,
  input  logic       cs_rise_evt,
  input  logic       pin_ok,
  input  logic       pin_fall_evt,
  input  logic       busy_i,
  output logic       txn,
  output logic       armed,
  output logic       sdo_oe_o,
  output logic       abort_o,
  output logic       corrupt_o,
  output logic [1:0] pwr_state_o
);
  logic txn_start;
  logic abort_evt;
  pwr_e pwr_now;

  assign txn_start = cs_fall_evt & pin_ok;
  assign abort_evt = pin_fall_evt & busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      txn       <= 1'b0;
      abort_o   <= 1'b0;
      corrupt_o <= 1'b0;
    end else begin
      if (!pin_ok)        armed <= 1'b0;
      else if (txn_start) armed <= 1'b1;

      if (!pin_ok || cs_rise_evt) txn <= 1'b0;
      else if (txn_start)         txn <= 1'b1;

      abort_o <= abort_evt;

      if (abort_evt)      corrupt_o <= 1'b1;
      else if (txn_start) corrupt_o <= 1'b0;
    end
  end

  assign pwr_now     = pwr_classify(pin_ok, cs_sel, busy_i);
  assign pwr_state_o = pwr_now;
  assign sdo_oe_o    = cs_sel & pin_ok;

  // R4
  txn_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn |-> armed);
  // R7
  pin_low_closes_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_ok |=> !txn);
  // R3
  cs_rise_closes_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_evt |=> !txn);
  // R9
  corrupt_with_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(corrupt_o) |-> abort_o);
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn,
  input  logic              sclk_rise,
  input  logic              sdi_s,
  output logic [CNT_W-1:0]  bit_idx,
  output logic              byte_seen,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              rx_instr_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  function automatic logic [DATA_W-1:0] shift_in(logic [DATA_W-1:0] sh, logic b);
    return {sh[DATA_W-2:0], b};
  endfunction

  logic [DATA_W-1:0] sh;
  logic              take_bit;
  logic              byte_done;

  assign take_bit  = txn & sclk_rise;
  assign byte_done = take_bit & (bit_idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh         <= '0;
      bit_idx    <= '0;
      byte_seen  <= 1'b0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
      rx_instr_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (!txn) begin
        sh        <= '0;
        bit_idx   <= '0;
        byte_seen <= 1'b0;
      end else if (take_bit) begin
        sh <= shift_in(sh, sdi_s);
        if (byte_done) begin
          bit_idx    <= '0;
          rx_byte_o  <= shift_in(sh, sdi_s);
          rx_valid_o <= 1'b1;
          rx_instr_o <= ~byte_seen;
          byte_seen  <= 1'b1;
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end

  // R1
  valid_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> $past(txn));
  // R1
  valid_after_last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> ($past(bit_idx) == LAST && bit_idx == '0));
  // R2
  data_after_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_instr_o) |-> $past(byte_seen));
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn,
  input  logic              sclk_fall,
  input  logic [CNT_W-1:0]  bit_idx,
  input  logic              byte_seen,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic              sdo_o
);
  logic [DATA_W-1:0] sh;
  logic              load_evt;
  logic              shift_evt;

  assign load_evt  = txn & sclk_fall & (bit_idx == '0) & byte_seen;
  assign shift_evt = txn & sclk_fall & (bit_idx != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sh <= '0;
    else if (!txn)      sh <= '0;
    else if (load_evt)  sh <= tx_byte_i;
    else if (shift_evt) sh <= {sh[DATA_W-2:0], 1'b0};
  end

  assign sdo_o = sh[DATA_W-1];

  // R5
  sdo_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sdo_o) && $past(txn)) |-> $past(sclk_fall));
endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
  import spi_fe_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              cs_n_i,
  input  logic              hw_rst_n_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              rx_instr_o,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              busy_i,
  output logic              abort_o,
  output logic              corrupt_o,
  output logic [1:0]        pwr_state_o
);
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int SETTLE = SYNC_STAGES + 1;

  logic sclk_s, sdi_s, cs_n_s, pin_s;
  logic sclk_rise, sclk_fall, cs_fall_evt, cs_rise_evt, pin_fall_evt;
  logic txn, armed, byte_seen;
  logic [CNT_W-1:0] bit_idx;

  spi_fe_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) i_sync_sclk
    (.clk(clk), .rst_n(rst_n), .d_i(sclk_i), .q_o(sclk_s));
  spi_fe_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) i_sync_sdi
    (.clk(clk), .rst_n(rst_n), .d_i(sdi_i), .q_o(sdi_s));
  spi_fe_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) i_sync_cs
    (.clk(clk), .rst_n(rst_n), .d_i(cs_n_i), .q_o(cs_n_s));
  spi_fe_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) i_sync_pin
    (.clk(clk), .rst_n(rst_n), .d_i(hw_rst_n_i), .q_o(pin_s));

  spi_fe_edge #(.RISING(1'b1), .SETTLE(SETTLE)) i_edge_sclk_r
    (.clk(clk), .rst_n(rst_n), .d_i(sclk_s), .pulse_o(sclk_rise));
  spi_fe_edge #(.RISING(1'b0), .SETTLE(SETTLE)) i_edge_sclk_f
    (.clk(clk), .rst_n(rst_n), .d_i(sclk_s), .pulse_o(sclk_fall));
  spi_fe_edge #(.RISING(1'b0), .SETTLE(SETTLE)) i_edge_cs_f
    (.clk(clk), .rst_n(rst_n), .d_i(cs_n_s), .pulse_o(cs_fall_evt));
  spi_fe_edge #(.RISING(1'b1), .SETTLE(SETTLE)) i_edge_cs_r
    (.clk(clk), .rst_n(rst_n), .d_i(cs_n_s), .pulse_o(cs_rise_evt));
  spi_fe_edge #(.RISING(1'b0), .SETTLE(SETTLE)) i_edge_pin_f
    (.clk(clk), .rst_n(rst_n), .d_i(pin_s), .pulse_o(pin_fall_evt));

  spi_fe_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cs_sel(~cs_n_s), .cs_fall_evt(cs_fall_evt), .cs_rise_evt(cs_rise_evt),
    .pin_ok(pin_s), .pin_fall_evt(pin_fall_evt), .busy_i(busy_i),
    .txn(txn), .armed(armed), .sdo_oe_o(sdo_oe_o),
    .abort_o(abort_o), .corrupt_o(corrupt_o), .pwr_state_o(pwr_state_o)
  );

  spi_fe_rx #(.DATA_W(DATA_W)) i_rx (
    .clk(clk), .rst_n(rst_n), .txn(txn), .sclk_rise(sclk_rise), .sdi_s(sdi_s),
    .bit_idx(bit_idx), .byte_seen(byte_seen),
    .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o), .rx_instr_o(rx_instr_o)
  );

  spi_fe_tx #(.DATA_W(DATA_W)) i_tx (
    .clk(clk), .rst_n(rst_n), .txn(txn), .sclk_fall(sclk_fall),
    .bit_idx(bit_idx), .byte_seen(byte_seen),
    .tx_byte_i(tx_byte_i), .sdo_o(sdo_o)
  );

  // R8
  active_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state_o == 2'b10) |-> sdo_oe_o);
  // R7
  reset_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state_o == 2'b00) |-> (!sdo_oe_o && !rx_valid_o));
  // R6
  deselect_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> !sdo_oe_o);
endmodule

// File: tb/test_spi_mem_frontend.sv
module test_spi_mem_frontend;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, hw_rst_n = 1'b1, busy = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic sdo, sdo_oe, rx_valid, rx_instr, abort_p, corrupt;
  logic [7:0] rx_byte;
  logic [1:0] pwr;

  int n_tests = 0, n_fail = 0, n_got = 0, n_abort = 0;
  logic [7:0] got_b [256];
  logic       got_i [256];
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_mem_frontend i_spi_mem_frontend (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .cs_n_i(cs_n),
    .hw_rst_n_i(hw_rst_n), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .rx_byte_o(rx_byte),
    .rx_valid_o(rx_valid), .rx_instr_o(rx_instr), .tx_byte_i(tx_byte),
    .busy_i(busy), .abort_o(abort_p), .corrupt_o(corrupt), .pwr_state_o(pwr)
  );

  function automatic logic [7:0] f_reply(logic [7:0] b);
    return {b[3:0], b[7:4]} ^ 8'h5A;
  endfunction

  // Core model and event recorder, sampled away from the active edge.
  always @(negedge clk) begin
    if (rx_valid) begin
      got_b[n_got % 256] = rx_byte;
      got_i[n_got % 256] = rx_instr;
      n_got++;
      tx_byte = f_reply(rx_byte);
    end
    if (abort_p) n_abort++;
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b, output logic seen);
    sdi = b;
    wclk(HALF);
    seen = sdo;
    sclk = 1'b1;
    wclk(HALF);
    sclk = 1'b0;
  endtask

  // Full transaction: nbytes whole bytes then extra stray bits.
  task automatic run_txn(int nbytes, int extra, string tag);
    logic [7:0] data [8];
    logic [7:0] shifted;
    logic s;
    int base;
    base = n_got;
    for (int k = 0; k < 8; k++) data[k] = 8'($urandom);
    cs_n = 1'b0;
    wclk(10);
    chk(sdo_oe == 1'b1, "R6 oe while selected", int'(sdo_oe), 1);
    for (int k = 0; k < nbytes; k++) begin
      shifted = 8'h00;
      for (int i = 7; i >= 0; i--) begin
        send_bit(data[k][i], s);
        shifted = {shifted[6:0], s};
      end
      if (k == 0) chk(shifted == 8'h00, "R5 sdo idle in instr byte", int'(shifted), 0);
      else chk(shifted == f_reply(data[k-1]), "R5 reply byte", int'(shifted), int'(f_reply(data[k-1])));
    end
    for (int i = 0; i < extra; i++) send_bit(1'($urandom), s);
    wclk(6);
    cs_n = 1'b1;
    wclk(12);
    chk(sdo_oe == 1'b0, "R6 oe off when deselected", int'(sdo_oe), 0);
    chk(n_got - base == nbytes, {tag, " byte count"}, n_got - base, nbytes);
    for (int k = 0; k < nbytes && k < n_got - base; k++) begin
      chk(got_b[(base + k) % 256] == data[k], k == 0 ? "R1 instr value" : "R2 data value",
          int'(got_b[(base + k) % 256]), int'(data[k]));
      chk(got_i[(base + k) % 256] == (k == 0), k == 0 ? "R1 instr flag" : "R2 data flag",
          int'(got_i[(base + k) % 256]), int'(k == 0));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog all-R actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed, base, ab;
    logic s;
    seed = int'($urandom(32'd20240611));
    wclk(4);
    rst_n = 1'b1;
    wclk(10);
    // Reset state
    chk(sdo_oe == 1'b0, "R6 reset oe", int'(sdo_oe), 0);
    chk(pwr == 2'b01, "R8 reset standby", int'(pwr), 1);
    chk(corrupt == 1'b0, "R9 reset corrupt", int'(corrupt), 0);
    chk(n_got == 0, "R1 no byte at reset", n_got, 0);

    // R4: chip select low across system reset release
    rst_n = 1'b0;
    cs_n = 1'b0;
    wclk(4);
    rst_n = 1'b1;
    wclk(10);
    base = n_got;
    for (int i = 0; i < 16; i++) send_bit(1'($urandom), s);
    wclk(8);
    chk(n_got == base, "R4 bits before cs fall dropped", n_got - base, 0);
    chk(pwr == 2'b10, "R8 active while selected", int'(pwr), 2);
    cs_n = 1'b1;
    wclk(12);
    run_txn(2, 0, "R4 first after fall");

    // Directed shapes
    run_txn(1, 0, "R1 single byte");
    run_txn(0, 5, "R3 partial only");
    run_txn(3, 3, "R3 partial tail");

    // Random transactions
    for (int t = 0; t < 25; t++) run_txn(int'($urandom % 6), int'($urandom % 8), "R2 random");

    // Power states
    busy = 1'b1;
    wclk(6);
    chk(pwr == 2'b11, "R8 busy deselected", int'(pwr), 3);
    cs_n = 1'b0;
    wclk(8);
    chk(pwr == 2'b10, "R8 busy but selected", int'(pwr), 2);
    cs_n = 1'b1;
    busy = 1'b0;
    wclk(8);
    chk(pwr == 2'b01, "R8 standby", int'(pwr), 1);

    // R7: reset pin mid-transaction, chip select kept low
    base = n_got;
    cs_n = 1'b0;
    wclk(10);
    for (int i = 0; i < 4; i++) send_bit(1'($urandom), s);
    hw_rst_n = 1'b0;
    wclk(8);
    chk(sdo_oe == 1'b0, "R7 oe off in reset", int'(sdo_oe), 0);
    chk(pwr == 2'b00, "R8 reset mode", int'(pwr), 0);
    for (int i = 0; i < 4; i++) send_bit(1'($urandom), s);
    hw_rst_n = 1'b1;
    wclk(8);
    for (int i = 0; i < 8; i++) send_bit(1'($urandom), s);
    wclk(8);
    chk(n_got == base, "R7 no byte until new cs fall", n_got - base, 0);
    chk(n_abort == 0, "R9 no abort when idle", n_abort, 0);
    cs_n = 1'b1;
    wclk(12);
    run_txn(2, 1, "R7 recovery");

    // R9: abort while busy
    ab = n_abort;
    busy = 1'b1;
    wclk(4);
    hw_rst_n = 1'b0;
    wclk(8);
    chk(n_abort - ab == 1, "R9 one abort pulse", n_abort - ab, 1);
    chk(corrupt == 1'b1, "R9 corrupt set", int'(corrupt), 1);
    busy = 1'b0;
    hw_rst_n = 1'b1;
    wclk(8);
    chk(corrupt == 1'b1, "R9 corrupt sticky", int'(corrupt), 1);
    cs_n = 1'b0;
    wclk(10);
    chk(corrupt == 1'b0, "R9 corrupt cleared by txn", int'(corrupt), 0);
    cs_n = 1'b1;
    wclk(12);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule